// File: doc/BRIEF.md
# Julia-set escape-time iteration engine

This block computes the escape count of one point of the complex plane under the Julia-set map z ← z² + c. It works in signed fixed point. A single start pulse loads the starting point z0, the constant c and the pixel coordinates of the point. The engine then performs one map step per clock. It stops when the squared magnitude of z exceeds 4 or when the iteration ceiling is reached.

On completion it pulses `done` for one cycle. Together with that pulse it presents three results:
- the escape count;
- the linear pixel-buffer index of the point;
- a 16-bit RGB565 colour looked up from a small palette indexed by the count.

A frame renderer feeds the engine one point at a time and writes the count or the colour at the returned index. Start pulses that arrive while a point is in progress are dropped.

Top module: `julia_engine`

## Requirements
- R1: After reset, `busy`, `done`, `count`, `colour` and `pix_idx` are all zero.
- R2: Values are signed Q4.28 (32 bits, 28 fraction bits). Each square or cross product is floored to 28 fraction bits in a 36-bit signed field. The next real part is the low 32 bits of xx − yy + c_re. The next imaginary part is the low 32 bits of 2·xy + c_im. `count` equals the number of steps applied before the escape test first succeeds.
- R3: The escape test is strict. It succeeds only when xx + yy > 4.0, so a point with |z|² exactly 4 keeps iterating. The test is applied to z0 before any step, so a z0 outside the circle gives count 0.
- R4: A point that has not escaped after 128 steps is reported with count 128. `count` never exceeds 128.
- R5: `done` is high for exactly one cycle. Counting the rising edge that samples `start` as the first edge, `done` rises on edge count + 2.
- R6: A `start` received while `busy` is high is ignored. The running point's count, colour and index are unaffected.
- R7: `colour` is 0x0000 for count 128. Otherwise, with n = count:
  - red (bits 15:11) is n·32/128;
  - green (bits 10:5) is n·64/128;
  - blue (bits 4:0) is 31 − red.
- R8: `pix_idx` equals pix_col + pix_row·320, taken from the values sampled with the accepted `start`.
- R9: `busy` is high from the edge after an accepted `start` until the edge that raises `done`, where it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a point when idle |
| z0_re | input | 32 | Starting real part, Q4.28 |
| z0_im | input | 32 | Starting imaginary part, Q4.28 |
| c_re | input | 32 | Constant real part, Q4.28 |
| c_im | input | 32 | Constant imaginary part, Q4.28 |
| pix_col | input | 9 | Pixel column |
| pix_row | input | 8 | Pixel row |
| busy | output | 1 | A point is in progress |
| done | output | 1 | One-cycle completion pulse |
| count | output | 8 | Escape count, 0 to 128 |
| colour | output | 16 | RGB565 colour of the count |
| pix_idx | output | 17 | Linear pixel-buffer index |

## Verification
The bench builds the engine with its default parameters:
- Q4.28 arithmetic;
- a ceiling of 128 with the palette enabled;
- a 320×240 frame.

With the 128 ceiling, the bench reaches both ends of the count range: points that escape at count 0, points that never escape, and the exact-radius point z0 = 2 that separates the strict test from a non-strict one. With the palette enabled, every returned count is checked against the computed colour, including the black entry for 128. With the frame width at 320, the index arithmetic is exercised at rows far from zero.

// File: rtl/julia_pkg.sv
package julia_pkg;

   // RGB565 palette entry for escape count n out of a ceiling of lim
   function automatic logic [15:0] pal_entry(input int n, input int lim);
      int r, g, b;
      r = (n * 32) / lim;
      g = (n * 64) / lim;
      b = 31 - r;
      return {r[4:0], g[5:0], b[4:0]};
   endfunction

endpackage

// File: rtl/julia_step.sv
module julia_step #(
   parameter int W    = 32,
   parameter int FRAC = 28
) (
   input  logic signed [W-1:0] x,
   input  logic signed [W-1:0] y,
   input  logic signed [W-1:0] cx,
   input  logic signed [W-1:0] cy,
   output logic signed [W-1:0] nx,
   output logic signed [W-1:0] ny,
   output logic                escape
);
   localparam int P_W = 2 * W - FRAC;
   localparam logic signed [P_W:0] LIM = (P_W + 1)'(4) <<< FRAC;

   generate
      if (FRAC >= W - 2) begin : g_bad
         $error("julia_step: FRAC must leave at least 3 integer bits");
      end
   endgenerate

   logic signed [2*W-1:0] xx_f, yy_f, xy_f;
   logic signed [P_W-1:0] xx_t, yy_t, xy_t, dre, dim;
   logic signed [P_W:0]   mag;

   always_comb begin
      xx_f = x * x;
      yy_f = y * y;
      xy_f = x * y;
      xx_t = P_W'(xx_f >>> FRAC);
      yy_t = P_W'(yy_f >>> FRAC);
      xy_t = P_W'(xy_f >>> FRAC);
      mag  = (P_W + 1)'(xx_t) + (P_W + 1)'(yy_t);
      escape = mag > LIM;
      dre  = xx_t - yy_t + P_W'(cx);
      dim  = (xy_t <<< 1) + P_W'(cy);
      nx   = dre[W-1:0];
      ny   = dim[W-1:0];
   end
endmodule

// File: rtl/julia_palette.sv
module julia_palette #(
   parameter int MAX_ITER   = 128,
   parameter int CNT_W      = 8,
   parameter bit PALETTE_EN = 1'b1
) (
   input  logic [CNT_W-1:0] n,
   output logic [15:0]      rgb
);
   import julia_pkg::*;

   generate
      if (MAX_ITER < 2 || (1 << CNT_W) <= MAX_ITER) begin : g_bad
         $error("julia_palette: bad MAX_ITER / CNT_W");
      end
      if (PALETTE_EN) begin : g_tab
         logic [15:0] tab [MAX_ITER];
         for (genvar i = 0; i < MAX_ITER; i++) begin : g_ent
            assign tab[i] = pal_entry(i, MAX_ITER);
         end
         always_comb begin
            if (int'(n) >= MAX_ITER) rgb = 16'h0000;
            else                     rgb = tab[n];
         end
      end else begin : g_off
         assign rgb = 16'h0000;
      end
   endgenerate

   always_comb begin
      if (int'(n) == MAX_ITER)
         AST_PAL_BLACK: assert (rgb == 16'h0000); // R7
   end
endmodule

// File: rtl/julia_engine.sv
module julia_engine #(
   parameter int W          = 32,
   parameter int FRAC       = 28,
   parameter int MAX_ITER   = 128,
   parameter int FRAME_W    = 320,
   parameter int FRAME_H    = 240,
   parameter bit PALETTE_EN = 1'b1,
   localparam int CNT_W     = $clog2(MAX_ITER + 1),
   localparam int COL_W     = $clog2(FRAME_W),
   localparam int ROW_W     = $clog2(FRAME_H),
   localparam int IDX_W     = $clog2(FRAME_W * FRAME_H)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic signed [W-1:0] z0_re,
   input  logic signed [W-1:0] z0_im,
   input  logic signed [W-1:0] c_re,
   input  logic signed [W-1:0] c_im,
   input  logic [COL_W-1:0]    pix_col,
   input  logic [ROW_W-1:0]    pix_row,
   output logic                busy,
   output logic                done,
   output logic [CNT_W-1:0]    count,
   output logic [15:0]         colour,
   output logic [IDX_W-1:0]    pix_idx
);
   localparam logic [CNT_W-1:0] CEIL = CNT_W'(MAX_ITER);

   generate
      if (FRAME_W < 2 || FRAME_H < 2) begin : g_bad
         $error("julia_engine: frame too small");
      end
   endgenerate

   logic signed [W-1:0] x_q, y_q, cx_q, cy_q, nx, ny;
   logic [CNT_W-1:0]    iter_q, cnt_q;
   logic [IDX_W-1:0]    idx_q, idx_in;
   logic [15:0]         rgb, rgb_q;
   logic                busy_q, done_q, esc, stop;

   julia_step #(.W(W), .FRAC(FRAC)) u_step (
      .x(x_q), .y(y_q), .cx(cx_q), .cy(cy_q),
      .nx(nx), .ny(ny), .escape(esc)
   );

   julia_palette #(.MAX_ITER(MAX_ITER), .CNT_W(CNT_W), .PALETTE_EN(PALETTE_EN)) u_pal (
      .n(iter_q), .rgb(rgb)
   );

   assign stop   = esc || (iter_q == CEIL);
   assign idx_in = IDX_W'(pix_col) + IDX_W'(pix_row) * IDX_W'(FRAME_W);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q    <= '0;
         y_q    <= '0;
         cx_q   <= '0;
         cy_q   <= '0;
         iter_q <= '0;
         cnt_q  <= '0;
         idx_q  <= '0;
         rgb_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               x_q    <= z0_re;
               y_q    <= z0_im;
               cx_q   <= c_re;
               cy_q   <= c_im;
               idx_q  <= idx_in;
               iter_q <= '0;
               busy_q <= 1'b1;
            end
         end else if (stop) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            cnt_q  <= iter_q;
            rgb_q  <= rgb;
         end else begin
            x_q    <= nx;
            y_q    <= ny;
            iter_q <= iter_q + 1'b1;
         end
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign count   = cnt_q;
   assign colour  = rgb_q;
   assign pix_idx = done_q ? idx_q : '0;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R5
   AST_COUNT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (cnt_q <= CEIL)); // R4
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start) |=> ($stable(cx_q) && $stable(cy_q) && $stable(idx_q))); // R6
   AST_BUSY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !stop) |=> (busy_q && iter_q == $past(iter_q) + 1'b1)); // R9
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> !busy_q); // R9
endmodule

// File: tb/sim_julia_engine.sv
module sim_julia_engine;
   localparam int CLK_NS = 10;
   localparam int FW     = 320;
   localparam int CEIL   = 128;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic signed [31:0] z0_re = '0, z0_im = '0, c_re = '0, c_im = '0;
   logic [8:0]         pix_col = '0;
   logic [7:0]         pix_row = '0;
   logic               busy, done;
   logic [7:0]         count;
   logic [15:0]        colour;
   logic [16:0]        pix_idx;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_NS / 2) clk = ~clk;

   julia_engine u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .z0_re(z0_re), .z0_im(z0_im), .c_re(c_re), .c_im(c_im),
      .pix_col(pix_col), .pix_row(pix_row),
      .busy(busy), .done(done), .count(count), .colour(colour), .pix_idx(pix_idx)
   );

   function automatic longint sx32(input longint v);
      logic signed [31:0] t;
      t = v[31:0];
      return longint'(t);
   endfunction

   function automatic int ref_count(input longint x0, input longint y0,
                                    input longint cx, input longint cy);
      longint x, y, xx, yy, xy;
      x = x0;
      y = y0;
      for (int n = 0; n <= CEIL; n++) begin
         xx = (x * x) >>> 28;
         yy = (y * y) >>> 28;
         xy = (x * y) >>> 28;
         if (xx + yy > (longint'(4) <<< 28)) return n;
         if (n == CEIL) return CEIL;
         x = sx32(xx - yy + cx);
         y = sx32(2 * xy + cy);
      end
      return CEIL;
   endfunction

   function automatic logic [15:0] ref_colour(input int n);
      int r, g;
      if (n == CEIL) return 16'h0000;
      r = n * 32 / CEIL;
      g = n * 64 / CEIL;
      return {5'(r), 6'(g), 5'(31 - r)};
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_point(input logic signed [31:0] x0, input logic signed [31:0] y0,
                            input logic signed [31:0] cx, input logic signed [31:0] cy,
                            input int col, input int row, input string req,
                            input bit poke);
      int exp_n, lat;
      exp_n = ref_count(longint'(x0), longint'(y0), longint'(cx), longint'(cy));
      @(negedge clk);
      z0_re = x0; z0_im = y0; c_re = cx; c_im = cy;
      pix_col = 9'(col); pix_row = 8'(row);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      check("R9 busy after start", longint'(busy), 1);
      if (poke) begin
         z0_re = 32'sh0800_0000; z0_im = '0; c_re = 32'sh1000_0000; c_im = '0;
         pix_col = 9'd7; pix_row = 8'd3;
         start = 1'b1;
      end
      while (!done && lat < 400) begin
         @(negedge clk);
         start = 1'b0;
         lat++;
      end
      check({req, " count"}, longint'(count), longint'(exp_n));
      check("R5 latency", longint'(lat), longint'(exp_n + 2));
      check("R7 colour", longint'(colour), longint'(ref_colour(exp_n)));
      check("R8 pix_idx", longint'(pix_idx), longint'(col + row * FW));
      check("R9 busy low at done", longint'(busy), 0);
      @(negedge clk);
      check("R5 done one cycle", longint'(done), 0);
   endtask

   initial begin
      #(CLK_NS * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int seed;
      logic signed [31:0] c0r, c0i;
      seed = $urandom(32'd4711);
      c0r = 32'sd76504269;
      c0i = 32'sd2684355;
      repeat (3) @(negedge clk);
      check("R1 busy", longint'(busy), 0);
      check("R1 done", longint'(done), 0);
      check("R1 count", longint'(count), 0);
      check("R1 colour", longint'(colour), 0);
      check("R1 pix_idx", longint'(pix_idx), 0);
      rst_n = 1'b1;

      // R4: origin with c = 0 never escapes
      run_point('0, '0, '0, '0, 5, 2, "R4", 1'b0);
      // R3: exactly radius 2 keeps iterating; one LSB beyond escapes at 0
      run_point(32'sh2000_0000, '0, '0, '0, 0, 0, "R3", 1'b0);
      run_point(32'sh2000_0001, '0, '0, '0, 319, 239, "R3", 1'b0);
      run_point('0, -32'sh2000_0001, '0, '0, 1, 1, "R3", 1'b0);
      // R6: start pulses during a run are dropped
      run_point('0, '0, '0, '0, 11, 100, "R6", 1'b1);
      // R2: reference constant, a few directed points
      run_point('0, '0, c0r, c0i, 160, 120, "R2", 1'b0);
      run_point(32'sh0800_0000, 32'sh0400_0000, c0r, c0i, 200, 50, "R2", 1'b0);
      run_point(-32'sh1000_0000, 32'sh0100_0000, c0r, c0i, 10, 230, "R2", 1'b0);
      // R2: constrained random points, |z0| components < 2, |c| components < 1
      for (int k = 0; k < 24; k++) begin
         logic signed [31:0] rx, ry, rcx, rcy;
         rx  = 32'($signed($urandom_range(0, 32'h3FFF_FFFF)) - 32'sh2000_0000);
         ry  = 32'($signed($urandom_range(0, 32'h3FFF_FFFF)) - 32'sh2000_0000);
         rcx = 32'($signed($urandom_range(0, 32'h1FFF_FFFF)) - 32'sh1000_0000);
         rcy = 32'($signed($urandom_range(0, 32'h1FFF_FFFF)) - 32'sh1000_0000);
         run_point(rx, ry, rcx, rcy, int'($urandom_range(0, FW - 1)),
                   int'($urandom_range(0, 239)), "R2", k[2]);
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule